// File: doc/BRIEF.md
# Strap Capture and Frequency-Source Control

This block sits between five dual-purpose package pins and the frequency synthesizer of a clock generator. While power-on reset is held, the pins are inputs carrying board-level strap resistors. The block samples their levels on every clock edge of the reset period, so the latch holds the last levels seen before release. It then turns the pins into clock outputs through a direction control.

After reset, the block picks the 5-bit frequency code handed to the synthesizer. The code comes either from the captured straps or from a code held in configuration byte 0, which software writes. The same byte also carries a spread-spectrum enable and a tristate-all request, which the block registers and forwards. The captured straps are also offered in inverted form for a serial readback path to place into its bytes. Software cannot write these readback bits.

Top module: `fsel_strap_ctrl`

## Requirements
- R1: While `por_n` is low at a clock edge, the outputs after that edge are as follows: `pin_oe_o`=0, `fs_eff_o`=0, `spread_en_o`=0 and `tristate_all_o`=0. Configuration byte 0 is cleared to 0 at the same time.
- R2: The strap latch holds the pin levels sampled at the last clock edge with `por_n` low. Pin changes after that edge leave the latch unchanged until reset is asserted again.
- R3: `pin_oe_o` becomes 1 on the first clock edge with `por_n` high and stays 1 until reset is asserted again.
- R4: Byte 0 is cleared by reset, so its source bit is 0. The first clock edge after release therefore puts the latched straps on `fs_eff_o`.
- R5: When byte 0 bit 3 is 1, `fs_eff_o` takes the code from the register. FS4 comes from bit 2, and FS3, FS2, FS1 and FS0 come from bits 7, 6, 5 and 4. When bit 3 is 0, bits 7:4 and bit 2 have no effect and the straps are used.
- R6: Byte 0 bit 1 drives `spread_en_o` (1 = centre spread on). Byte 0 bit 0 drives `tristate_all_o` (1 = all clock outputs tristated).
- R7: All three outputs are registered. A write to byte 0 is taken at clock edge j. The outputs still show the old values after edge j and show the new values after edge j+1.
- R8: `strap_rb_n_o[i]` equals the inverse of latched strap FSi. The readback path places bit 2 at byte 1 bit 7, bit 1 at byte 1 bit 6, bit 0 at byte 2 bit 7, bit 4 at byte 3 bit 7 and bit 3 at byte 3 bit 4.
- R9: Only writes with `cfg_addr_i`=0 change byte 0. Writes to any other address change none of the outputs, including the strap readback bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| pin_lvl_i | input | 5 | Raw levels of the shared strap pins, index = FS number |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| fs_eff_o | output | 5 | Effective frequency code FS[4:0] to the synthesizer |
| pin_oe_o | output | 1 | 1 = shared pins drive clocks, 0 = shared pins are inputs |
| spread_en_o | output | 1 | Spread-spectrum enable |
| tristate_all_o | output | 1 | Tristate request for all clock outputs |
| strap_rb_n_o | output | 5 | Inverted latched straps for readback |

## Verification
The hardest situation to reach is the strap latch ignoring pin activity after release. From the ports, a latch that kept tracking the pins for one extra cycle looks almost correct. The stimulus therefore holds one strap pattern across the release edge and changes the pins at once to its complement. It then checks both the readback and the effective code over several cycles. A second reset in the middle of the run uses a different pattern, which shows that the latch takes new values and that byte 0 goes back to selecting the straps.

// File: rtl/fsel_pkg.sv
// Shared widths and byte-0 field positions for the strap and frequency-source control.
// Assumes byte 0 layout is fixed by the serial register map seen by software.
package fsel_pkg;
    localparam int FS_W       = 5;
    localparam int CFG_W      = 8;
    localparam int ADDR_W     = 3;
    localparam int SRC_BIT    = 3;   // 1 = register code, 0 = straps
    localparam int FS4_BIT    = 2;   // register FS4
    localparam int SPREAD_BIT = 1;
    localparam int TRI_BIT    = 0;
    localparam int FSLO_MSB   = 7;   // bits 7:4 carry FS3..FS0
    localparam int FSLO_LSB   = 4;

    typedef struct packed {
        logic [FS_W-1:0] fs;
        logic            spread;
        logic            tri_all;
    } sel_out_t;
endpackage

// File: rtl/fsel_strap_latch.sv
// Captures the shared pin levels during power-on reset and switches the pins to output mode
// after release. Assumes por_n is already synchronous to clk.
module fsel_strap_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] strap_o,
    output logic [W-1:0] strap_n_o,
    output logic         oe_o
);
    logic [W-1:0] strap_q;
    logic         oe_q;

    // Track the pins while in reset; freeze them and enable the outputs once released.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            strap_q <= pin_i;
            oe_q    <= 1'b0;
        end else begin
            oe_q    <= 1'b1;
        end
    end

    // Per-bit inverted copy for the readback path.
    for (genvar i = 0; i < W; i++) begin : g_inv
        assign strap_n_o[i] = ~strap_q[i];
    end

    assign strap_o = strap_q;
    assign oe_o    = oe_q;
endmodule

// File: rtl/fsel_cfg_reg.sv
// Holds configuration byte 0. Only address 0 is decoded here; other addresses belong to
// registers elsewhere. Assumes a single-cycle write strobe.
module fsel_cfg_reg #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] byte0_o
);
    logic [DW-1:0] byte0_q;

    // Clear on reset, load on a write addressed to byte 0.
    always_ff @(posedge clk) begin
        if (!por_n)
            byte0_q <= '0;
        else if (we_i && (addr_i == '0))
            byte0_q <= wdata_i;
    end

    assign byte0_o = byte0_q;
endmodule

// File: rtl/fsel_src_sel.sv
// Chooses the frequency code source and registers the code with the spread and tristate
// controls, so a source change never produces a partial code. Assumes byte 0 layout from fsel_pkg.
module fsel_src_sel
    import fsel_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic [CFG_W-1:0] byte0_i,
    input  logic [FS_W-1:0]  strap_i,
    output sel_out_t         sel_o
);
    logic [FS_W-1:0] reg_code;
    sel_out_t        nxt;
    sel_out_t        sel_q;

    // Assemble the register code and pick the source.
    always_comb begin
        reg_code    = {byte0_i[FS4_BIT], byte0_i[FSLO_MSB:FSLO_LSB]};
        nxt.fs      = byte0_i[SRC_BIT] ? reg_code : strap_i;
        nxt.spread  = byte0_i[SPREAD_BIT];
        nxt.tri_all = byte0_i[TRI_BIT];
    end

    // Register all controls together.
    always_ff @(posedge clk) begin
        if (!por_n)
            sel_q <= '0;
        else
            sel_q <= nxt;
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/fsel_strap_ctrl.sv
// Top: strap capture, frequency-source selection and spread/tristate control.
// Assumes por_n is synchronous and held low for at least one clock edge.
module fsel_strap_ctrl
    import fsel_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic [FS_W-1:0]   pin_lvl_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    output logic [FS_W-1:0]   fs_eff_o,
    output logic              pin_oe_o,
    output logic              spread_en_o,
    output logic              tristate_all_o,
    output logic [FS_W-1:0]   strap_rb_n_o
);
    logic [FS_W-1:0]  strap_w;
    logic [CFG_W-1:0] byte0_w;
    sel_out_t         sel_w;

    fsel_strap_latch #(.W(FS_W)) u_latch (
        .clk      (clk),
        .por_n    (por_n),
        .pin_i    (pin_lvl_i),
        .strap_o  (strap_w),
        .strap_n_o(strap_rb_n_o),
        .oe_o     (pin_oe_o)
    );

    fsel_cfg_reg #(.DW(CFG_W), .AW(ADDR_W)) u_cfg (
        .clk    (clk),
        .por_n  (por_n),
        .we_i   (cfg_we_i),
        .addr_i (cfg_addr_i),
        .wdata_i(cfg_wdata_i),
        .byte0_o(byte0_w)
    );

    fsel_src_sel u_sel (
        .clk    (clk),
        .por_n  (por_n),
        .byte0_i(byte0_w),
        .strap_i(strap_w),
        .sel_o  (sel_w)
    );

    assign fs_eff_o       = sel_w.fs;
    assign spread_en_o    = sel_w.spread;
    assign tristate_all_o = sel_w.tri_all;
endmodule

// File: rtl/fsel_strap_ctrl_chk.sv
// Property checker for fsel_strap_ctrl, attached by bind. Observes ports and byte 0.
module fsel_strap_ctrl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       cfg_we_i,
    input logic [2:0] cfg_addr_i,
    input logic [7:0] byte0,
    input logic [4:0] fs_eff_o,
    input logic       pin_oe_o,
    input logic       spread_en_o,
    input logic       tristate_all_o,
    input logic [4:0] strap_rb_n_o
);
    logic rst_seen_q;

    // Remember whether the last edge was a reset edge.
    always_ff @(posedge clk) rst_seen_q <= !por_n;

    // R1: after a reset edge everything is quiet.
    always @(negedge clk) begin
        if (rst_seen_q)
            p_reset_quiet_r1: assert (!pin_oe_o && fs_eff_o == 5'd0 && !spread_en_o
                                      && !tristate_all_o && byte0 == 8'd0);
    end

    // R3: output mode follows release and persists.
    p_oe_on_r3: assert property (@(posedge clk) disable iff (!por_n) por_n |=> pin_oe_o);

    // R2: once outputs are on, the latch does not move.
    p_strap_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
        pin_oe_o |=> $stable(strap_rb_n_o));

    // R4: strap source reaches the code one edge later.
    p_strap_src_r4: assert property (@(posedge clk) disable iff (!por_n)
        !byte0[3] |=> (fs_eff_o == ~$past(strap_rb_n_o)));

    // R5: register source reaches the code one edge later.
    p_reg_src_r5: assert property (@(posedge clk) disable iff (!por_n)
        byte0[3] |=> (fs_eff_o == {$past(byte0[2]), $past(byte0[7:4])}));

    // R6: spread and tristate follow byte 0 one edge later.
    p_ctl_bits_r6: assert property (@(posedge clk) disable iff (!por_n)
        por_n |=> (spread_en_o == $past(byte0[1]) && tristate_all_o == $past(byte0[0])));

    // R9: writes to other addresses leave byte 0 alone.
    p_other_addr_r9: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_we_i && cfg_addr_i != 3'd0) |=> $stable(byte0));
endmodule

bind fsel_strap_ctrl fsel_strap_ctrl_chk u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .cfg_we_i      (cfg_we_i),
    .cfg_addr_i    (cfg_addr_i),
    .byte0         (byte0_w),
    .fs_eff_o      (fs_eff_o),
    .pin_oe_o      (pin_oe_o),
    .spread_en_o   (spread_en_o),
    .tristate_all_o(tristate_all_o),
    .strap_rb_n_o  (strap_rb_n_o)
);

// File: tb/tb_fsel_strap_ctrl.sv
`timescale 1ns/1ps
module tb_fsel_strap_ctrl;
    logic       clk = 1'b0;
    logic       por_n;
    logic [4:0] pin_lvl_i;
    logic       cfg_we_i;
    logic [2:0] cfg_addr_i;
    logic [7:0] cfg_wdata_i;
    logic [4:0] fs_eff_o;
    logic       pin_oe_o;
    logic       spread_en_o;
    logic       tristate_all_o;
    logic [4:0] strap_rb_n_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fsel_strap_ctrl dut (.*);

    // Vector: {byte0[7:0], expected fs[4:0], spread, tristate}; straps latched = 5'b10110.
    localparam int NV = 9;
    localparam logic [14:0] VEC [NV] = '{
        {8'h00, 5'b10110, 1'b0, 1'b0},
        {8'h02, 5'b10110, 1'b1, 1'b0},
        {8'h01, 5'b10110, 1'b0, 1'b1},
        {8'h08, 5'b00000, 1'b0, 1'b0},
        {8'hFC, 5'b11111, 1'b0, 1'b0},
        {8'hAB, 5'b01010, 1'b1, 1'b1},
        {8'h5C, 5'b10101, 1'b0, 1'b0},
        {8'hF0, 5'b10110, 1'b0, 1'b0},
        {8'h7D, 5'b10111, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Issue one write; returns at the negedge right after the capturing edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    initial begin
        por_n = 1'b0; pin_lvl_i = 5'b10110;
        cfg_we_i = 1'b0; cfg_addr_i = '0; cfg_wdata_i = '0;
        repeat (4) @(negedge clk);
        chk("R1 oe in reset", {31'd0, pin_oe_o}, 32'd0);
        chk("R1 code in reset", {27'd0, fs_eff_o}, 32'd0);
        chk("R1 ctl in reset", {30'd0, spread_en_o, tristate_all_o}, 32'd0);

        // Release; first edge after this sees por_n high.
        por_n = 1'b1;
        @(negedge clk);
        chk("R3 oe after release", {31'd0, pin_oe_o}, 32'd1);
        chk("R4 code from straps", {27'd0, fs_eff_o}, 32'h16);
        chk("R8 readback inverted", {27'd0, strap_rb_n_o}, 32'h09);
        pin_lvl_i = 5'b01001;
        repeat (3) @(negedge clk);
        chk("R2 latch ignores pins rb", {27'd0, strap_rb_n_o}, 32'h09);
        chk("R2 latch ignores pins fs", {27'd0, fs_eff_o}, 32'h16);
        chk("R3 oe stays", {31'd0, pin_oe_o}, 32'd1);

        // Writes to other addresses.
        wr(3'd1, 8'hFF);
        wr(3'd3, 8'h0B);
        @(negedge clk);
        chk("R9 rb unchanged", {27'd0, strap_rb_n_o}, 32'h09);
        chk("R9 outputs unchanged", {25'd0, fs_eff_o, spread_en_o, tristate_all_o}, {25'd0, 5'b10110, 2'b00});

        // Table walk (R5, R6).
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, VEC[i][14:7]);
            @(negedge clk);
            chk($sformatf("R5 code vec%0d", i), {27'd0, fs_eff_o}, {27'd0, VEC[i][6:2]});
            chk($sformatf("R6 ctl vec%0d", i), {30'd0, spread_en_o, tristate_all_o}, {30'd0, VEC[i][1:0]});
        end

        // R7: one-edge latency after the write edge.
        wr(3'd0, 8'h08);
        chk("R7 old code after write edge", {27'd0, fs_eff_o}, 32'h17);
        chk("R7 old ctl after write edge", {31'd0, tristate_all_o}, 32'd1);
        @(negedge clk);
        chk("R7 new code next edge", {27'd0, fs_eff_o}, 32'h00);
        chk("R7 new ctl next edge", {31'd0, tristate_all_o}, 32'd0);

        // Second reset with a new strap pattern.
        por_n = 1'b0; pin_lvl_i = 5'b00011;
        @(negedge clk);
        chk("R1 oe on re-reset", {31'd0, pin_oe_o}, 32'd0);
        chk("R1 code on re-reset", {27'd0, fs_eff_o}, 32'd0);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        pin_lvl_i = 5'b11100;
        chk("R4 byte0 cleared, straps used", {27'd0, fs_eff_o}, 32'h03);
        chk("R8 new readback", {27'd0, strap_rb_n_o}, 32'h1C);
        repeat (2) @(negedge clk);
        chk("R2 second latch holds", {27'd0, strap_rb_n_o}, 32'h1C);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule